// File: doc/BRIEF.md
# Upper-Memory Shadow Route Controller

This block holds a small indexed set of configuration registers and decodes every memory access that falls in the 256 KB window from 0xC0000 to 0xFFFFF. Software reaches the registers through two 8-bit I/O ports. A write to the index port picks a register. The data port then reads or writes that register. From the stored settings, the decoder tells the memory controller where the presented access must go. A read goes either to internal shadow DRAM or to the external bus where the ROMs sit. A write goes to internal DRAM, goes to the external bus, or is dropped.

The window is split into four 64 KB banks. The three lower banks (C, D and E) are each cut into four 16 KB segments. Every segment has its own read-shadow bit and its own write-shadow bit. A write-protect bit for the whole bank overrides the segment write bits. The top bank (F) has a single read-source bit and a single write-protect bit.

The route outputs are combinational from the presented address and access type. No data moves through the block, so no valid/ready handshake is used. Every pin is a plain level, and a register write affects routing from the clock edge that stores it.

Top module: `shadow_route_ctrl`

## Requirements
- R1: A write to I/O address 0x22 loads the 8-bit index register, which resets to 0x00. A read at 0x22 returns the current index. A read at any I/O address other than 0x22 or 0x24 returns 0xFF.
- R2: Through I/O address 0x24, registers 0x23 to 0x27 can be written and read back. After reset, 0x23 reads 0x40 and 0x24 to 0x27 read 0x00.
- R3: Any other index reads 0xFF at the data port, and a write to it changes no register.
- R4: Register 0x26 controls bank C (0xC0000–0xCFFFF), 0x25 controls bank D and 0x24 controls bank E. The segment number i is address bits [15:14]. A read of segment i returns 00 (internal) when bit 4+i is set and 01 (external) when it is clear.
- R5: A write to segment i of bank C, D or E returns 00 when bit i of the bank's register is set and 01 when it is clear, as long as the bank is not protected.
- R6: Bits 4, 5 and 6 of register 0x27 protect banks C, D and E. A write to a protected bank returns 10 (dropped), whatever its segment bits say. Each bit affects only its own bank.
- R7: A read in bank F (0xF0000–0xFFFFF) returns 01 when bit 6 of register 0x23 is set and 00 when it is clear.
- R8: A write in bank F returns 10 when bit 7 of register 0x27 is set and 00 otherwise.
- R9: An address below 0xC0000 or above 0xFFFFF (24-bit bus) drives in_window low and route to 01. Every address inside the window drives in_window high.
- R10: A read never returns 10. Protect bits have no effect on read routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 24 | Memory access address |
| mem_wr | input | 1 | 1 = write access, 0 = read access |
| route | output | 2 | 00 internal, 01 external, 10 dropped |
| in_window | output | 1 | Address lies in 0xC0000–0xFFFFF |

## Verification
The hardest case to reach is protect priority. It only shows when a segment's write-shadow bit is set and, at the same time, its bank is protected while a neighbouring bank is not. The stimulus table builds this state step by step. It enables a write segment in banks E and D, then moves the single protect bit from E to D to C. After each move it probes a write in the protected bank and a write in a bank just released. A read of a protected segment is also probed, to show that protection never reaches the read path.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int NUM_SEG_BANKS = 3;
  localparam int SEGS_PER_BANK = 4;

  typedef enum logic [1:0] {
    ROUTE_INT  = 2'b00,
    ROUTE_EXT  = 2'b01,
    ROUTE_DROP = 2'b10
  } route_e;

  // Register layout: upper nibble read shadow, lower nibble write shadow
  typedef struct packed {
    logic [SEGS_PER_BANK-1:0] rd_shadow;
    logic [SEGS_PER_BANK-1:0] wr_shadow;
  } seg_ctl_t;

  typedef struct packed {
    seg_ctl_t [NUM_SEG_BANKS-1:0] seg;     // index 0 = C, 1 = D, 2 = E
    logic [NUM_SEG_BANKS-1:0]     seg_wp;
    logic                         top_rd_ext;
    logic                         top_wp;
  } shadow_cfg_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
#(
  parameter logic [7:0] IDX_PORT   = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h24,
  parameter logic [7:0] REG_TOP    = 8'h23,
  parameter logic [7:0] REG_SEG_HI = 8'h26,
  parameter logic [7:0] REG_PROT   = 8'h27,
  parameter logic [7:0] TOP_RST    = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output shadow_cfg_t cfg
);
  logic [7:0] idx_q, top_q, prot_q;
  logic [NUM_SEG_BANKS-1:0][7:0] seg_q;
  logic data_wr, idx_wr, idx_impl;
  logic [7:0] data_rd;

  assign idx_wr  = io_wr && (io_addr == IDX_PORT);
  assign data_wr = io_wr && (io_addr == DATA_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= 8'h00;
      top_q  <= TOP_RST;
      prot_q <= 8'h00;
    end else begin
      if (idx_wr) idx_q <= io_wdata;
      if (data_wr && idx_q == REG_TOP)  top_q  <= io_wdata;
      if (data_wr && idx_q == REG_PROT) prot_q <= io_wdata;
    end
  end

  for (genvar b = 0; b < NUM_SEG_BANKS; b++) begin : g_seg
    localparam logic [7:0] MY_IDX = REG_SEG_HI - 8'(b);
    always_ff @(posedge clk) begin
      if (!rst_n)                          seg_q[b] <= 8'h00;
      else if (data_wr && idx_q == MY_IDX) seg_q[b] <= io_wdata;
    end
    assign cfg.seg[b]    = seg_ctl_t'(seg_q[b]);
    assign cfg.seg_wp[b] = prot_q[4+b];
  end

  assign cfg.top_rd_ext = top_q[6];
  assign cfg.top_wp     = prot_q[7];

  always_comb begin
    data_rd  = 8'hFF;
    idx_impl = 1'b0;
    if (idx_q == REG_TOP)  begin data_rd = top_q;  idx_impl = 1'b1; end
    if (idx_q == REG_PROT) begin data_rd = prot_q; idx_impl = 1'b1; end
    for (int b = 0; b < NUM_SEG_BANKS; b++) begin
      if (idx_q == REG_SEG_HI - 8'(b)) begin
        data_rd  = seg_q[b];
        idx_impl = 1'b1;
      end
    end
  end

  always_comb begin
    if (io_addr == IDX_PORT)       io_rdata = idx_q;
    else if (io_addr == DATA_PORT) io_rdata = data_rd;
    else                           io_rdata = 8'hFF;
  end

  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(io_wdata));

  a_r2_prot_load: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == REG_PROT) |=> prot_q == $past(io_wdata));

  a_r3_unimpl_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_impl) |=> ($stable(top_q) && $stable(prot_q) && $stable(seg_q)));
endmodule

// File: rtl/shadow_route_decode.sv
module shadow_route_decode
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  shadow_cfg_t       cfg,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wr,
  output route_e            route,
  output logic              in_window
);
  localparam int HI_W = ADDR_W - 20;

  logic [1:0] bank;
  logic [1:0] seg;
  seg_ctl_t   sc;

  assign in_window = (mem_addr[ADDR_W-1:20] == HI_W'(0)) && (mem_addr[19:18] == 2'b11);
  assign bank      = mem_addr[17:16];
  assign seg       = mem_addr[15:14];

  always_comb begin
    route = ROUTE_EXT;
    sc    = '0;
    if (in_window) begin
      if (bank == 2'd3) begin
        if (mem_wr) route = cfg.top_wp     ? ROUTE_DROP : ROUTE_INT;
        else        route = cfg.top_rd_ext ? ROUTE_EXT  : ROUTE_INT;
      end else begin
        sc = cfg.seg[bank];
        if (mem_wr)
          route = cfg.seg_wp[bank] ? ROUTE_DROP
                                   : (sc.wr_shadow[seg] ? ROUTE_INT : ROUTE_EXT);
        else
          route = sc.rd_shadow[seg] ? ROUTE_INT : ROUTE_EXT;
      end
    end
  end

  always_comb begin
    if (in_window !== 1'b1 && in_window !== 1'b0) begin
    end else begin
      a_r10_read_never_dropped: assert (mem_wr || route != ROUTE_DROP);
      a_r9_outside_external: assert (in_window || route == ROUTE_EXT);
    end
  end
endmodule

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
  import shadow_pkg::*;
#(
  parameter int         ADDR_W    = 24,
  parameter logic [7:0] IDX_PORT  = 8'h22,
  parameter logic [7:0] DATA_PORT = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wr,
  output logic [1:0]        route,
  output logic              in_window
);
  shadow_cfg_t cfg;
  route_e      route_d;

  shadow_cfg_regs #(
    .IDX_PORT (IDX_PORT),
    .DATA_PORT(DATA_PORT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .cfg     (cfg)
  );

  shadow_route_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cfg      (cfg),
    .mem_addr (mem_addr),
    .mem_wr   (mem_wr),
    .route    (route_d),
    .in_window(in_window)
  );

  assign route = route_d;

  a_r6_protect_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && mem_wr && mem_addr[17:16] != 2'd3 && cfg.seg_wp[mem_addr[17:16]])
      |-> route == 2'b10);

  a_r8_top_write_route: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && mem_wr && mem_addr[17:16] == 2'd3)
      |-> route == (cfg.top_wp ? 2'b10 : 2'b00));
endmodule

// File: tb/tb_shadow_route_ctrl.sv
module tb_shadow_route_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  io_addr = 8'h00;
  logic        io_wr = 0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [23:0] mem_addr = 24'h0;
  logic        mem_wr = 0;
  logic [1:0]  route;
  logic        in_window;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shadow_route_ctrl dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .route(route), .in_window(in_window)
  );

  typedef struct packed {
    logic [7:0]  idx;
    logic [7:0]  val;
    logic [23:0] addr;
    logic        wr;
    logic [1:0]  rt;
    logic        win;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{8'h26, 8'h10, 24'h0C0000, 1'b0, 2'b00, 1'b1, 8'd4},  // R4 C seg0 read shadow
    '{8'h26, 8'h10, 24'h0C4000, 1'b0, 2'b01, 1'b1, 8'd4},  // R4 C seg1 external
    '{8'h26, 8'h10, 24'h0C0000, 1'b1, 2'b01, 1'b1, 8'd5},  // R5 write bit clear
    '{8'h25, 8'h08, 24'h0DC000, 1'b1, 2'b00, 1'b1, 8'd5},  // R5 D seg3 write shadow
    '{8'h25, 8'h08, 24'h0DC000, 1'b0, 2'b01, 1'b1, 8'd4},  // R4 D seg3 read ext
    '{8'h24, 8'h82, 24'h0EC123, 1'b0, 2'b00, 1'b1, 8'd4},  // R4 E seg3 read int
    '{8'h24, 8'h82, 24'h0E4000, 1'b1, 2'b00, 1'b1, 8'd5},  // R5 E seg1 write int
    '{8'h27, 8'h40, 24'h0E4000, 1'b1, 2'b10, 1'b1, 8'd6},  // R6 E protected
    '{8'h27, 8'h40, 24'h0EC000, 1'b0, 2'b00, 1'b1, 8'd10}, // R10 read unaffected
    '{8'h27, 8'h40, 24'h0DC000, 1'b1, 2'b00, 1'b1, 8'd6},  // R6 D not protected
    '{8'h27, 8'h20, 24'h0DC000, 1'b1, 2'b10, 1'b1, 8'd6},  // R6 D protected
    '{8'h27, 8'h20, 24'h0E4000, 1'b1, 2'b00, 1'b1, 8'd6},  // R6 E released
    '{8'h27, 8'h10, 24'h0C8000, 1'b1, 2'b10, 1'b1, 8'd6},  // R6 C protected
    '{8'h23, 8'h00, 24'h0F8000, 1'b0, 2'b00, 1'b1, 8'd7},  // R7 top read internal
    '{8'h23, 8'h40, 24'h0FFFFF, 1'b0, 2'b01, 1'b1, 8'd7},  // R7 top read external
    '{8'h27, 8'h00, 24'h0F0000, 1'b1, 2'b00, 1'b1, 8'd8},  // R8 top write internal
    '{8'h27, 8'h80, 24'h0F0000, 1'b1, 2'b10, 1'b1, 8'd8},  // R8 top write dropped
    '{8'h27, 8'h80, 24'h0BFFFF, 1'b0, 2'b01, 1'b0, 8'd9},  // R9 below window
    '{8'h27, 8'h80, 24'h100000, 1'b1, 2'b01, 1'b0, 8'd9}   // R9 above window
  };

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    io_addr = a;
    #2 d = io_rdata;
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [23:0] a, input logic w,
                       input logic [1:0] rt, input logic win);
    mem_addr = a; mem_wr = w;
    #2;
    checks++;
    if (route !== rt || in_window !== win) begin
      failures++;
      $display("FAIL %s: addr=%06h wr=%0b actual route=%02b win=%0b expected route=%02b win=%0b",
               req, a, w, route, in_window, rt, win);
    end
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    io_read(8'h22, d); check8("R1 index reset", d, 8'h00);
    io_write(8'h22, 8'h23);
    io_read(8'h24, d); check8("R2 reg23 reset", d, 8'h40);
    io_write(8'h22, 8'h27);
    io_read(8'h24, d); check8("R2 reg27 reset", d, 8'h00);
    probe("R4 reset C read external", 24'h0C0000, 1'b0, 2'b01, 1'b1);
    probe("R7 reset top read external", 24'h0F0000, 1'b0, 2'b01, 1'b1);
    probe("R8 reset top write internal", 24'h0F0000, 1'b1, 2'b00, 1'b1);

    // table walk
    for (int k = 0; k < NV; k++) begin
      io_write(8'h22, VEC[k].idx);
      io_write(8'h24, VEC[k].val);
      probe($sformatf("R%0d vec%0d", VEC[k].req, k), VEC[k].addr, VEC[k].wr,
            VEC[k].rt, VEC[k].win);
    end

    // R1: index read back, stray port
    io_write(8'h22, 8'h5C);
    io_read(8'h22, d); check8("R1 index readback", d, 8'h5C);
    io_read(8'h30, d); check8("R1 other port reads FF", d, 8'hFF);

    // R2: register read back after table
    io_write(8'h22, 8'h24);
    io_read(8'h24, d); check8("R2 reg24 readback", d, 8'h82);
    io_write(8'h22, 8'h27);
    io_read(8'h24, d); check8("R2 reg27 readback", d, 8'h80);

    // R3: unimplemented index
    io_write(8'h22, 8'h28);
    io_write(8'h24, 8'h00);
    io_read(8'h24, d); check8("R3 unimpl reads FF", d, 8'hFF);
    io_write(8'h22, 8'h00);
    io_write(8'h24, 8'h3C);
    io_read(8'h24, d); check8("R3 idx00 reads FF", d, 8'hFF);
    probe("R3 routing kept after ignored writes", 24'h0F0000, 1'b1, 2'b10, 1'b1);
    probe("R3 E seg3 read kept", 24'h0EC000, 1'b0, 2'b00, 1'b1);
    io_write(8'h22, 8'h27);
    io_read(8'h24, d); check8("R3 reg27 unchanged", d, 8'h80);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule